// File: doc/BRIEF.md
# Peripheral DMA Request Generator

This block sits in the data path of a peripheral such as a storage-card host and decides which of four DMA request lines to raise at each step of a transfer: burst, single, last-burst or last-single. A transfer starts when a word count and a direction are presented with a start pulse while the block is idle. The block then walks the remaining count down as each request is acknowledged by a one-cycle `dma_done` pulse from the DMA engine. A request is only raised when the FIFO can take the whole request (transmit) or already holds all of it (receive).

The burst length is a parameter with a default of 8 words. While more than one burst remains, full bursts are requested. The end of a transfer depends on the direction. Transmit finishes with a single last-burst request that covers the whole remainder of 1 to 8 words. Receive never asks for more words than remain: an exact final 8 words goes out as a last-burst, and any smaller remainder is drained one word at a time with single requests, ending with a last-single request for the final word.

The control is a four-state machine. ST_IDLE goes to ST_ARM on a start pulse with a nonzero count (the count and the direction are latched). ST_ARM goes to ST_REQ once the FIFO level covers the request chosen for the current remainder. ST_REQ holds its one request line and waits for `dma_done`. On an acknowledge of a non-final request it returns to ST_ARM, and on an acknowledge of a final request it moves to ST_FINISH. ST_FINISH pulses the completion flag for one cycle and returns to ST_IDLE.

Top module: `dma_req_gen`

## Requirements
- R1: A `start` pulse in idle with a nonzero `word_count` latches the count and `dir_tx` (1 = transmit, 0 = receive). `busy` is high from the next cycle.
- R2: In transmit, while more than BURST_LEN words remain, the burst line is requested, and each acknowledge removes BURST_LEN words.
- R3: In transmit, once 1 to BURST_LEN words remain, exactly one last-burst request covers them all and ends the transfer.
- R4: In receive, while more than BURST_LEN words remain, the burst line is requested (less BURST_LEN per acknowledge). When exactly BURST_LEN remain, a last-burst request ends the transfer.
- R5: In receive, when 2 to BURST_LEN-1 words remain, each request is a single (less 1 per acknowledge). The final word is requested with last-single, so no request ever exceeds the remaining count.
- R6: At most one of the four request lines is high in any cycle.
- R7: A raised request line stays high and unchanged until `dma_done`. It is low in the cycle after the acknowledge.
- R8: A request rises only if, in the cycle before, the FIFO level (`tx_room` in transmit, `rx_fill` in receive) was at least the words it asks for. That is BURST_LEN for a burst, the remainder for a last-burst, and 1 for a single or a last-single.
- R9: `xfer_done` is high for exactly one cycle, the cycle after the final request is acknowledged. After it, `busy` is low.
- R10: A `start` with `word_count` of zero, or a `start` while busy, has no effect: no request is raised and a running sequence is unchanged.
- R11: A `dma_done` pulse while no request line is high has no effect on the request sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only in idle |
| word_count | input | CNT_W | Words to transfer, sampled with start |
| dir_tx | input | 1 | 1 = transmit, 0 = receive, sampled with start |
| tx_room | input | LVL_W | Free words in the transmit FIFO |
| rx_fill | input | LVL_W | Stored words in the receive FIFO |
| dma_done | input | 1 | One-cycle acknowledge of the current request |
| req_burst | output | 1 | Burst request |
| req_single | output | 1 | Single-word request |
| req_last_burst | output | 1 | Final burst request |
| req_last_single | output | 1 | Final single-word request |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the block with its defaults: an 8-word burst, a 16-bit count and a 16-word FIFO. These make the 31- and 32-word cases and exact multiples of the burst reachable in short runs, and give a FIFO level wide enough to hold a level one below every request size. Counts of 1 to 40 in both directions cover every remainder class: zero, one, two to seven, exactly eight, and above eight. For each request the FIFO level is held one word short before it is released, which probes the readiness threshold at its exact edge.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    // Request kinds; the value is the bit index of the matching output line.
    typedef enum logic [1:0] {
        RK_BURST       = 2'd0,
        RK_SINGLE      = 2'd1,
        RK_LAST_BURST  = 2'd2,
        RK_LAST_SINGLE = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARM    = 2'd1,
        ST_REQ    = 2'd2,
        ST_FINISH = 2'd3
    } fsm_state_e;

    localparam int NUM_LINES = 4;

    function automatic logic kind_is_final(req_kind_e k);
        return (k == RK_LAST_BURST) || (k == RK_LAST_SINGLE);
    endfunction

endpackage

// File: rtl/dmarq_count.sv
module dmarq_count
    import dmarq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_dir,
    input  logic             step,
    input  req_kind_e        step_kind,
    output logic [CNT_W-1:0] remain,
    output logic             dir_q
);

    localparam logic [CNT_W-1:0] BURST_WORDS = CNT_W'(BURST_LEN);
    localparam logic [CNT_W-1:0] ONE_WORD    = CNT_W'(1);

    logic [CNT_W-1:0] remain_nxt;

    always_comb begin
        remain_nxt = remain;
        if (load) begin
            remain_nxt = load_val;
        end else if (step) begin
            unique case (step_kind)
                RK_BURST:       remain_nxt = remain - BURST_WORDS;
                RK_SINGLE:      remain_nxt = remain - ONE_WORD;
                RK_LAST_BURST:  remain_nxt = '0;
                RK_LAST_SINGLE: remain_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            dir_q  <= 1'b0;
        end else begin
            remain <= remain_nxt;
            if (load) begin
                dir_q <= load_dir;
            end
        end
    end

endmodule

// File: rtl/dmarq_select.sv
module dmarq_select
    import dmarq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 8,
    parameter int LVL_W     = 5
) (
    input  logic [CNT_W-1:0] remain,
    input  logic             dir_tx,
    input  logic [LVL_W-1:0] tx_room,
    input  logic [LVL_W-1:0] rx_fill,
    output req_kind_e        kind,
    output logic             fifo_ok
);

    localparam int NEED_W = $clog2(BURST_LEN + 1);
    localparam int CMP_W  = (NEED_W > LVL_W) ? NEED_W : LVL_W;
    localparam logic [CNT_W-1:0] BURST_WORDS = CNT_W'(BURST_LEN);
    localparam logic [CNT_W-1:0] ONE_WORD    = CNT_W'(1);

    logic [NEED_W-1:0] need;
    logic [LVL_W-1:0]  level;
    logic              over_burst;
    logic              at_burst;

    assign over_burst = (remain > BURST_WORDS);
    assign at_burst   = (remain == BURST_WORDS);

    // Kind of the next request for the current remainder and direction.
    always_comb begin
        if (over_burst) begin
            kind = RK_BURST;
        end else if (dir_tx || at_burst) begin
            kind = RK_LAST_BURST;
        end else if (remain > ONE_WORD) begin
            kind = RK_SINGLE;
        end else begin
            kind = RK_LAST_SINGLE;
        end
    end

    // Words the request moves; the last burst carries the whole remainder.
    always_comb begin
        unique case (kind)
            RK_BURST:       need = NEED_W'(BURST_LEN);
            RK_LAST_BURST:  need = remain[NEED_W-1:0];
            RK_SINGLE:      need = NEED_W'(1);
            RK_LAST_SINGLE: need = NEED_W'(1);
        endcase
    end

    assign level   = dir_tx ? tx_room : rx_fill;
    assign fifo_ok = (CMP_W'(level) >= CMP_W'(need));

endmodule

// File: rtl/dmarq_fsm.sv
module dmarq_fsm
    import dmarq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] word_count,
    input  logic             fifo_ok,
    input  req_kind_e        kind_in,
    input  logic             dma_done,
    output logic             load,
    output logic             step,
    output req_kind_e        kind_q,
    output logic             req_active,
    output logic             xfer_done,
    output logic             busy
);

    fsm_state_e state;
    fsm_state_e state_nxt;
    logic       start_ok;
    logic       grant;

    assign start_ok = start && (word_count != '0);
    assign grant    = (state == ST_ARM) && fifo_ok;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start_ok) state_nxt = ST_ARM;
            ST_ARM:    if (fifo_ok)  state_nxt = ST_REQ;
            ST_REQ: begin
                if (dma_done) begin
                    state_nxt = kind_is_final(kind_q) ? ST_FINISH : ST_ARM;
                end
            end
            ST_FINISH: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= RK_BURST;
        end else begin
            state <= state_nxt;
            if (grant) begin
                kind_q <= kind_in;
            end
        end
    end

    always_comb begin
        load       = (state == ST_IDLE) && start_ok;
        step       = (state == ST_REQ) && dma_done;
        req_active = (state == ST_REQ);
        xfer_done  = (state == ST_FINISH);
        busy       = (state != ST_IDLE);
    end

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
    import dmarq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int BURST_LEN  = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] word_count,
    input  logic             dir_tx,
    input  logic [LVL_W-1:0] tx_room,
    input  logic [LVL_W-1:0] rx_fill,
    input  logic             dma_done,
    output logic             req_burst,
    output logic             req_single,
    output logic             req_last_burst,
    output logic             req_last_single,
    output logic             xfer_done,
    output logic             busy
);

    logic [CNT_W-1:0]     remain;
    logic                 dir_q;
    logic                 load;
    logic                 step;
    logic                 fifo_ok;
    logic                 req_active;
    req_kind_e            kind_sel;
    req_kind_e            kind_q;
    logic [NUM_LINES-1:0] lines;

    dmarq_count #(
        .CNT_W     (CNT_W),
        .BURST_LEN (BURST_LEN)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (word_count),
        .load_dir  (dir_tx),
        .step      (step),
        .step_kind (kind_q),
        .remain    (remain),
        .dir_q     (dir_q)
    );

    dmarq_select #(
        .CNT_W     (CNT_W),
        .BURST_LEN (BURST_LEN),
        .LVL_W     (LVL_W)
    ) u_select (
        .remain  (remain),
        .dir_tx  (dir_q),
        .tx_room (tx_room),
        .rx_fill (rx_fill),
        .kind    (kind_sel),
        .fifo_ok (fifo_ok)
    );

    dmarq_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_count (word_count),
        .fifo_ok    (fifo_ok),
        .kind_in    (kind_sel),
        .dma_done   (dma_done),
        .load       (load),
        .step       (step),
        .kind_q     (kind_q),
        .req_active (req_active),
        .xfer_done  (xfer_done),
        .busy       (busy)
    );

    // One line per request kind, decoded from the held kind.
    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        assign lines[gi] = req_active && (kind_q == req_kind_e'(gi));
    end

    assign req_burst       = lines[RK_BURST];
    assign req_single      = lines[RK_SINGLE];
    assign req_last_burst  = lines[RK_LAST_BURST];
    assign req_last_single = lines[RK_LAST_SINGLE];

endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 8,
    parameter int LVL_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] word_count,
    input logic             dir_q,
    input logic [LVL_W-1:0] tx_room,
    input logic [LVL_W-1:0] rx_fill,
    input logic             dma_done,
    input logic             req_burst,
    input logic             req_single,
    input logic             req_last_burst,
    input logic             req_last_single,
    input logic             xfer_done,
    input logic             busy
);

    logic [3:0]       reqs;
    logic [LVL_W-1:0] lvl;
    assign reqs = {req_last_single, req_last_burst, req_single, req_burst};
    assign lvl  = dir_q ? tx_room : rx_fill;

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && word_count != '0) |=> busy);

    p_tx_no_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_single || req_last_single) |-> !dir_q);

    p_one_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(reqs) <= 1);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reqs != 4'b0 && !dma_done) |=> (reqs == $past(reqs)));

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reqs != 4'b0 && dma_done) |=> (reqs == 4'b0));

    p_burst_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_burst) |-> ($past(lvl) >= LVL_W'(BURST_LEN)));

    p_single_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_single) || $rose(req_last_single)) |-> ($past(lvl) != '0));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (!xfer_done && !busy));

    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> $past(dma_done && (req_last_burst || req_last_single)));

    p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && word_count == '0) |=> !busy);

    p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reqs == 4'b0 && dma_done && !xfer_done) |=> busy);

endmodule

bind dma_req_gen dma_req_gen_chk #(
    .CNT_W     (CNT_W),
    .BURST_LEN (BURST_LEN),
    .LVL_W     (LVL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .word_count      (word_count),
    .dir_q           (dir_q),
    .tx_room         (tx_room),
    .rx_fill         (rx_fill),
    .dma_done        (dma_done),
    .req_burst       (req_burst),
    .req_single      (req_single),
    .req_last_burst  (req_last_burst),
    .req_last_single (req_last_single),
    .xfer_done       (xfer_done),
    .busy            (busy)
);

// File: tb/dma_req_gen_tb.sv
`timescale 1ns/1ps
module dma_req_gen_tb;

    localparam int CNT_W      = 16;
    localparam int BURST_LEN  = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] word_count = '0;
    logic             dir_tx = 1'b0;
    logic [LVL_W-1:0] lvl = '0;
    logic             dma_done = 1'b0;
    logic             req_burst, req_single, req_last_burst, req_last_single;
    logic             xfer_done, busy;
    logic [3:0]       reqs;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign reqs = {req_last_single, req_last_burst, req_single, req_burst};

    dma_req_gen #(
        .CNT_W      (CNT_W),
        .BURST_LEN  (BURST_LEN),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .word_count      (word_count),
        .dir_tx          (dir_tx),
        .tx_room         (lvl),
        .rx_fill         (lvl),
        .dma_done        (dma_done),
        .req_burst       (req_burst),
        .req_single      (req_single),
        .req_last_burst  (req_last_burst),
        .req_last_single (req_last_single),
        .xfer_done       (xfer_done),
        .busy            (busy)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected request: 0 burst, 1 single, 2 last-burst, 3 last-single.
    function automatic int exp_kind(int rem, bit tx);
        if (rem > BURST_LEN) return 0;
        if (tx || rem == BURST_LEN) return 2;
        if (rem > 1) return 1;
        return 3;
    endfunction

    function automatic int exp_words(int k, int rem);
        if (k == 0) return BURST_LEN;
        if (k == 2) return rem;
        return 1;
    endfunction

    function automatic string kind_tag(int k, bit tx);
        if (tx) return (k == 0) ? "R2" : "R3";
        return (k <= 0) ? "R4" : (k == 2) ? "R4" : "R5";
    endfunction

    task automatic run_xfer(input int count, input bit tx,
                            input bit poke_start, input bit poke_done);
        int rem;
        @(negedge clk);
        start = 1'b1; word_count = CNT_W'(count); dir_tx = tx; lvl = '0;
        @(negedge clk);
        start = 1'b0; dir_tx = ~tx;
        if (count == 0) begin
            for (int i = 0; i < 3; i++) begin
                check(!busy && reqs == 4'b0, "R10", "zero count started", int'(busy), 0);
                @(negedge clk);
            end
            return;
        end
        check(busy, "R1", "busy after start", int'(busy), 1);
        rem = count;
        while (rem > 0) begin
            int k, need, hold;
            bit seen;
            k    = exp_kind(rem, tx);
            need = exp_words(k, rem);
            lvl  = LVL_W'(need - 1);
            for (int i = 0; i < 3; i++) begin
                if (i == 0 && poke_done) dma_done = 1'b1;
                if (i == 0 && poke_start) begin
                    start = 1'b1; word_count = CNT_W'(3);
                end
                @(negedge clk);
                dma_done = 1'b0; start = 1'b0;
                check(reqs == 4'b0, "R8", "request with FIFO one short", int'(reqs), 0);
            end
            lvl = LVL_W'(need);
            seen = 1'b0;
            for (int i = 0; i < 4 && !seen; i++) begin
                @(negedge clk);
                seen = (reqs != 4'b0);
            end
            check(seen, "R8", "no request once FIFO ready", int'(reqs), 1 << k);
            check(reqs == 4'(1 << k), kind_tag(k, tx), "request line", int'(reqs), 1 << k);
            hold = int'($urandom % 3);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check(reqs == 4'(1 << k), "R7", "line not held", int'(reqs), 1 << k);
            end
            dma_done = 1'b1;
            @(negedge clk);
            dma_done = 1'b0; lvl = '0;
            check(reqs == 4'b0, "R7", "line high after ack", int'(reqs), 0);
            rem -= need;
            if (rem > 0) begin
                check(!xfer_done, "R9", "early done", int'(xfer_done), 0);
            end else begin
                check(xfer_done, "R9", "done pulse", int'(xfer_done), 1);
                @(negedge clk);
                check(!xfer_done && !busy, "R9", "done not one cycle",
                      int'({xfer_done, busy}), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reqs == 4'b0 && !busy && !xfer_done, "R6", "reset state",
              int'({reqs, busy, xfer_done}), 0);
        // directed corners
        run_xfer(32, 1'b1, 1'b0, 1'b0);
        run_xfer(31, 1'b0, 1'b0, 1'b0);
        run_xfer(32, 1'b0, 1'b0, 1'b0);
        run_xfer(31, 1'b1, 1'b0, 1'b0);
        run_xfer(5,  1'b1, 1'b0, 1'b0);
        run_xfer(1,  1'b0, 1'b0, 1'b0);
        run_xfer(8,  1'b1, 1'b0, 1'b0);
        run_xfer(9,  1'b0, 1'b0, 1'b0);
        run_xfer(2,  1'b0, 1'b0, 1'b0);
        run_xfer(0,  1'b1, 1'b0, 1'b0);
        run_xfer(0,  1'b0, 1'b0, 1'b0);
        run_xfer(19, 1'b0, 1'b1, 1'b0);
        run_xfer(17, 1'b1, 1'b0, 1'b1);
        run_xfer(14, 1'b0, 1'b1, 1'b1);
        // random mix
        for (int t = 0; t < 40; t++) begin
            run_xfer(int'($urandom % 41), 1'($urandom % 2),
                     1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule